// File: doc/BRIEF.md
# Interrupt Delay and Moderation Controller

This block sits in a network interface, between the completion logic of the transmit and receive queues and the single interrupt line. It decides when a completion becomes a visible interrupt. Each direction has two delay timers. The per-packet timer goes back to its full value on every qualifying completion. The absolute timer is armed once and is then left alone until it expires. When either timer of a direction expires, the block pulses a writeback request for that direction's used descriptors and, on the same clock edge, sets that direction's cause bit.

Causes raised by a software cause-set write, by a small received packet, or by a flush-on-read of the receive delay setting go through a throttle. Once armed, the throttle counts out its interval and is not restarted by later requests. Causes raised by timer expiry skip the throttle. The interrupt line is the OR of the cause bits that the mask enables, and only after a post has happened. A read strobe clears every cause bit.

All inputs are plain control pins: single-cycle pulses and register values. The block has no streaming data path, so it uses no valid/ready handshake and has no back-pressure.

Top module: `irq_moderator`

## Requirements
- R1: A transmit completion with `tx_ide`=1 restarts the transmit per-packet timer from `tx_pkt_dly`×`TICK_CYC` cycles, even if the timer is already running. This happens only when `tx_pkt_dly` is nonzero. A completion with `tx_ide`=0 starts no timer.
- R2: A qualifying completion arms the absolute timer with `abs_dly`×`TICK_CYC` cycles only when both the per-packet and absolute values are nonzero and the absolute timer is idle. Later completions do not extend it.
- R3: A transmit timer expiry pulses `tx_wb_req` for one cycle and sets cause bit 0 on the same edge. The first edge at which this is visible is N×`TICK_CYC` edges after the edge that sampled the completion.
- R4: The receive timers follow the same rules with `rx_done` (no request flag needed). On expiry they pulse `rx_wb_req` and set cause bit 1.
- R5: A throttled request arms the throttle for `thr_ivl`×`THR_CYC` cycles, and the line is posted when that count ends. A request that arrives while the throttle is counting does not restart it. When `thr_ivl`=0, the request is posted at once.
- R6: `ics_we` ORs `ics_data` into the cause bits on the next edge. This is a throttled request.
- R7: A `rx_done` with `rx_len` ≤ `small_thr` sets cause bit 2 on the next edge. This is a throttled request. A longer packet does not set it.
- R8: `flush_set` sets `flush_pend`. If `rx_dly_rd` arrives while `flush_pend` is set, the block pulses `rx_wb_req`, sets cause bit 1 (throttled) and clears `flush_pend` on the next edge. If `rx_dly_rd` arrives while `flush_pend` is clear, nothing happens.
- R9: A timer expiry posts the line on the same edge that sets the cause, whatever the throttle interval.
- R10: `irq_o` is high only when a post has happened and (`cause_o` & `mask`) is nonzero. `cause_rd` clears all cause bits on the next edge and drops the line. Bits set on that same edge survive the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| tx_done | input | 1 | Transmit descriptor completion pulse |
| tx_ide | input | 1 | Completed descriptor asks for a delayed interrupt |
| rx_done | input | 1 | Receive packet completion pulse |
| rx_len | input | LEN_W | Length of the completed receive packet |
| tx_pkt_dly | input | DLY_W | Transmit per-packet delay, in ticks |
| tx_abs_dly | input | DLY_W | Transmit absolute delay, in ticks |
| rx_pkt_dly | input | DLY_W | Receive per-packet delay, in ticks |
| rx_abs_dly | input | DLY_W | Receive absolute delay, in ticks |
| small_thr | input | LEN_W | Small-packet length threshold |
| thr_ivl | input | ITR_W | Throttle interval, in throttle units |
| ics_we | input | 1 | Software cause-set write strobe |
| ics_data | input | CAUSE_W | Cause bits to set |
| cause_rd | input | 1 | Cause read strobe, clears all causes |
| mask | input | CAUSE_W | Cause enable mask |
| flush_set | input | 1 | Sets the receive flush flag |
| rx_dly_rd | input | 1 | Read strobe of the receive delay setting |
| tx_wb_req | output | 1 | Transmit descriptor writeback request pulse |
| rx_wb_req | output | 1 | Receive descriptor writeback request pulse |
| flush_pend | output | 1 | Receive flush flag |
| cause_o | output | CAUSE_W | Cause bits |
| irq_o | output | 1 | Interrupt line |

## Verification
The bench builds the block with `CLK_PERIOD_NS`=20, `TICK_NS`=80 and `THR_NS`=40. With these values one delay tick is 4 cycles and one throttle unit is 2 cycles. Timer expiries, restarts within a running window, the absolute-timer cap and the throttle window therefore each fall within a few dozen cycles, and each can be checked at the exact edge where it lands. The default widths are kept, so the threshold comparisons and the mask behaviour run at their full size.

// File: rtl/irqmod_pkg.sv
package irqmod_pkg;
  localparam int CAUSE_W   = 8;
  localparam int TX_BIT    = 0;
  localparam int RX_BIT    = 1;
  localparam int SMALL_BIT = 2;
  localparam int NDIR      = 2;

  // clock cycles per unit of time, rounded, never zero
  function automatic int cyc_per(input int unit_ns, input int period_ns);
    int c;
    c = (unit_ns + period_ns / 2) / period_ns;
    return (c < 1) ? 1 : c;
  endfunction
endpackage

// File: rtl/dly_pair.sv
module dly_pair #(
  parameter int DLY_W    = 16,
  parameter int TICK_CYC = 256
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             done,
  input  logic [DLY_W-1:0] pkt_dly,
  input  logic [DLY_W-1:0] abs_dly,
  output logic             fire
);
  localparam int CNT_W = DLY_W + $clog2(TICK_CYC + 1);

  logic [CNT_W-1:0] pkt_cnt, abs_cnt;
  logic pkt_load, abs_load, pkt_exp, abs_exp;

  assign pkt_load = done && (pkt_dly != '0);
  assign abs_load = pkt_load && (abs_dly != '0) && (abs_cnt == '0);
  assign pkt_exp  = (pkt_cnt == CNT_W'(1)) && !pkt_load;
  assign abs_exp  = (abs_cnt == CNT_W'(1));
  assign fire     = pkt_exp || abs_exp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pkt_cnt <= '0;
      abs_cnt <= '0;
    end else begin
      if (pkt_load)
        pkt_cnt <= CNT_W'(pkt_dly) * CNT_W'(TICK_CYC);
      else if (pkt_cnt != '0)
        pkt_cnt <= pkt_cnt - 1'b1;
      if (abs_load)
        abs_cnt <= CNT_W'(abs_dly) * CNT_W'(TICK_CYC);
      else if (abs_cnt != '0)
        abs_cnt <= abs_cnt - 1'b1;
    end
  end

  // R2
  abs_no_extend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (abs_cnt > CNT_W'(1)) |=> (abs_cnt == $past(abs_cnt) - 1'b1));

  // R1
  pkt_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && pkt_dly != '0) |=> (pkt_cnt == CNT_W'($past(pkt_dly)) * CNT_W'(TICK_CYC)));
endmodule

// File: rtl/irq_throttle.sv
module irq_throttle #(
  parameter int ITR_W    = 16,
  parameter int UNIT_CYC = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_thr,
  input  logic             req_now,
  input  logic             pend,
  input  logic             clr,
  input  logic [ITR_W-1:0] ivl,
  output logic             posted
);
  localparam int CNT_W = ITR_W + $clog2(UNIT_CYC + 1);

  logic [CNT_W-1:0] cnt;
  logic start, done, post_set;

  assign start    = req_thr && !req_now && (ivl != '0) && (cnt == '0);
  assign done     = (cnt == CNT_W'(1));
  assign post_set = req_now || (req_thr && ivl == '0) || (done && pend);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      posted <= 1'b0;
    end else begin
      if (start)
        cnt <= CNT_W'(ivl) * CNT_W'(UNIT_CYC);
      else if (cnt != '0)
        cnt <= cnt - 1'b1;
      if (post_set)
        posted <= 1'b1;
      else if (clr)
        posted <= 1'b0;
    end
  end

  // R5
  thr_no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt > CNT_W'(1)) |=> (cnt == $past(cnt) - 1'b1));

  // R9
  now_posts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_now |=> posted);
endmodule

// File: rtl/irq_moderator.sv
module irq_moderator
  import irqmod_pkg::*;
#(
  parameter int CLK_PERIOD_NS = 4,
  parameter int TICK_NS       = 1024,
  parameter int THR_NS        = 256,
  parameter int DLY_W         = 16,
  parameter int LEN_W         = 14,
  parameter int ITR_W         = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tx_done,
  input  logic               tx_ide,
  input  logic               rx_done,
  input  logic [LEN_W-1:0]   rx_len,
  input  logic [DLY_W-1:0]   tx_pkt_dly,
  input  logic [DLY_W-1:0]   tx_abs_dly,
  input  logic [DLY_W-1:0]   rx_pkt_dly,
  input  logic [DLY_W-1:0]   rx_abs_dly,
  input  logic [LEN_W-1:0]   small_thr,
  input  logic [ITR_W-1:0]   thr_ivl,
  input  logic               ics_we,
  input  logic [CAUSE_W-1:0] ics_data,
  input  logic               cause_rd,
  input  logic [CAUSE_W-1:0] mask,
  input  logic               flush_set,
  input  logic               rx_dly_rd,
  output logic               tx_wb_req,
  output logic               rx_wb_req,
  output logic               flush_pend,
  output logic [CAUSE_W-1:0] cause_o,
  output logic               irq_o
);
  localparam int TICK_CYC = cyc_per(TICK_NS, CLK_PERIOD_NS);
  localparam int THR_CYC  = cyc_per(THR_NS, CLK_PERIOD_NS);

  logic [NDIR-1:0]  done_v, fire_v;
  logic [DLY_W-1:0] pkt_v [NDIR];
  logic [DLY_W-1:0] abs_v [NDIR];

  assign done_v[TX_BIT] = tx_done && tx_ide;
  assign done_v[RX_BIT] = rx_done;
  assign pkt_v[TX_BIT]  = tx_pkt_dly;
  assign pkt_v[RX_BIT]  = rx_pkt_dly;
  assign abs_v[TX_BIT]  = tx_abs_dly;
  assign abs_v[RX_BIT]  = rx_abs_dly;

  for (genvar d = 0; d < NDIR; d++) begin : g_dir
    dly_pair #(.DLY_W(DLY_W), .TICK_CYC(TICK_CYC)) u_dly (
      .clk(clk), .rst_n(rst_n), .done(done_v[d]),
      .pkt_dly(pkt_v[d]), .abs_dly(abs_v[d]), .fire(fire_v[d])
    );
  end

  logic [CAUSE_W-1:0] cause_q, cause_d, set_now, set_thr;
  logic flush_q, flush_hit, small_hit, posted;
  logic tx_wb_q, rx_wb_q;

  assign flush_hit = rx_dly_rd && flush_q;
  assign small_hit = rx_done && (rx_len <= small_thr);

  always_comb begin
    set_now = '0;
    set_now[TX_BIT] = fire_v[TX_BIT];
    set_now[RX_BIT] = fire_v[RX_BIT];
    set_thr = ics_we ? ics_data : '0;
    set_thr[SMALL_BIT] = set_thr[SMALL_BIT] | small_hit;
    set_thr[RX_BIT]    = set_thr[RX_BIT] | flush_hit;
    cause_d = (cause_rd ? '0 : cause_q) | set_now | set_thr;
  end

  irq_throttle #(.ITR_W(ITR_W), .UNIT_CYC(THR_CYC)) u_thr (
    .clk(clk), .rst_n(rst_n),
    .req_thr(|(set_thr & mask)), .req_now(|(set_now & mask)),
    .pend(|(cause_d & mask)), .clr(cause_rd), .ivl(thr_ivl), .posted(posted)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cause_q <= '0;
      flush_q <= 1'b0;
      tx_wb_q <= 1'b0;
      rx_wb_q <= 1'b0;
    end else begin
      cause_q <= cause_d;
      tx_wb_q <= fire_v[TX_BIT];
      rx_wb_q <= fire_v[RX_BIT] || flush_hit;
      if (flush_set)
        flush_q <= 1'b1;
      else if (flush_hit)
        flush_q <= 1'b0;
    end
  end

  assign tx_wb_req  = tx_wb_q;
  assign rx_wb_req  = rx_wb_q;
  assign flush_pend = flush_q;
  assign cause_o    = cause_q;
  assign irq_o      = posted && (|(cause_q & mask));

  // R3
  tx_wb_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_wb_req |-> cause_o[TX_BIT]);

  // R4
  rx_wb_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_wb_req |-> cause_o[RX_BIT]);

  // R7
  small_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && rx_len <= small_thr) |=> cause_o[SMALL_BIT]);

  // R8
  flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_dly_rd && flush_pend && !flush_set) |=> (!flush_pend && rx_wb_req));

  // R10
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (|(cause_o & mask)));
endmodule

// File: tb/irq_moderator_tb.sv
module irq_moderator_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_done = 0, tx_ide = 0, rx_done = 0;
  logic [13:0] rx_len = '0, small_thr = '0;
  logic [15:0] tx_pkt_dly = '0, tx_abs_dly = '0, rx_pkt_dly = '0, rx_abs_dly = '0;
  logic [15:0] thr_ivl = '0;
  logic ics_we = 0, cause_rd = 0, flush_set = 0, rx_dly_rd = 0;
  logic [7:0] ics_data = '0, mask = '0;
  logic tx_wb_req, rx_wb_req, flush_pend, irq_o;
  logic [7:0] cause_o;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  irq_moderator #(.CLK_PERIOD_NS(20), .TICK_NS(80), .THR_NS(40)) u_dut (
    .clk(clk), .rst_n(rst_n), .tx_done(tx_done), .tx_ide(tx_ide),
    .rx_done(rx_done), .rx_len(rx_len), .tx_pkt_dly(tx_pkt_dly),
    .tx_abs_dly(tx_abs_dly), .rx_pkt_dly(rx_pkt_dly), .rx_abs_dly(rx_abs_dly),
    .small_thr(small_thr), .thr_ivl(thr_ivl), .ics_we(ics_we),
    .ics_data(ics_data), .cause_rd(cause_rd), .mask(mask),
    .flush_set(flush_set), .rx_dly_rd(rx_dly_rd), .tx_wb_req(tx_wb_req),
    .rx_wb_req(rx_wb_req), .flush_pend(flush_pend), .cause_o(cause_o),
    .irq_o(irq_o)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic clear_causes();
    cause_rd = 1; step(1); cause_rd = 0;
  endtask

  task automatic t_reset();
    chk("R10 reset cause", cause_o, 0);
    chk("R10 reset irq", irq_o, 0);
    chk("R3 reset tx_wb", tx_wb_req, 0);
    chk("R8 reset flush", flush_pend, 0);
  endtask

  // R1 R3 R9: restart of the per-packet timer, expiry bypasses the throttle
  task automatic t_tx_restart();
    tx_pkt_dly = 3; tx_abs_dly = 0; mask = 8'h01; thr_ivl = 5;
    tx_done = 1; tx_ide = 1; step(1); tx_done = 0;
    step(5);
    tx_done = 1; step(1); tx_done = 0;       // second pulse, now at n1+1
    step(6);
    chk("R1 no early fire", cause_o[0], 0);
    step(5);
    chk("R1 still quiet", cause_o[0], 0);
    step(1);
    chk("R3 tx cause", cause_o[0], 1);
    chk("R3 tx_wb pulse", tx_wb_req, 1);
    chk("R9 immediate irq", irq_o, 1);
    step(1);
    chk("R3 tx_wb one cycle", tx_wb_req, 0);
    clear_causes();
    chk("R10 cleared cause", cause_o, 0);
    chk("R10 irq dropped", irq_o, 0);
    tx_ide = 0;
  endtask

  // R2: absolute timer is not extended
  task automatic t_tx_abs();
    tx_pkt_dly = 5; tx_abs_dly = 4; mask = 8'h01; thr_ivl = 0;
    tx_ide = 1;
    tx_done = 1; step(1); tx_done = 0;       // n0+1
    step(5);
    tx_done = 1; step(1); tx_done = 0;       // n0+7
    step(5);
    tx_done = 1; step(1); tx_done = 0;       // n0+13
    step(3);
    chk("R2 abs before", cause_o[0], 0);
    step(1);
    chk("R2 abs fired", cause_o[0], 1);
    chk("R2 abs wb", tx_wb_req, 1);
    clear_causes();                          // n0+18
    step(14);
    chk("R1 pkt before", cause_o[0], 0);
    step(1);
    chk("R1 pkt fired", cause_o[0], 1);
    clear_causes();
    tx_ide = 0;
  endtask

  // R1 R2: no timer without the request flag or with zero per-packet delay
  task automatic t_tx_ignored();
    tx_pkt_dly = 0; tx_abs_dly = 2; tx_ide = 1;
    tx_done = 1; step(1); tx_done = 0;
    step(20);
    chk("R2 abs needs pkt delay", cause_o[0], 0);
    tx_pkt_dly = 2; tx_ide = 0;
    tx_done = 1; step(1); tx_done = 0;
    step(20);
    chk("R1 ide clear ignored", cause_o[0], 0);
    chk("R1 ide clear no wb", tx_wb_req, 0);
    tx_pkt_dly = 0; tx_abs_dly = 0;
  endtask

  // R4 R10: receive timer, masked off line
  task automatic t_rx_timer();
    rx_pkt_dly = 2; rx_abs_dly = 0; small_thr = 64; rx_len = 1000; mask = 8'h00;
    rx_done = 1; step(1); rx_done = 0;
    step(7);
    chk("R4 rx before", cause_o[1], 0);
    step(1);
    chk("R4 rx cause", cause_o, 8'h02);
    chk("R4 rx_wb", rx_wb_req, 1);
    chk("R10 masked irq", irq_o, 0);
    clear_causes();
    rx_pkt_dly = 0;
  endtask

  // R7: small packet threshold boundary
  task automatic t_small();
    small_thr = 64; rx_len = 64; mask = 8'h00;
    rx_done = 1; step(1); rx_done = 0;
    chk("R7 at threshold", cause_o, 8'h04);
    clear_causes();
    rx_len = 65;
    rx_done = 1; step(1); rx_done = 0;
    chk("R7 above threshold", cause_o, 8'h00);
  endtask

  // R5 R6: throttle window, no restart
  task automatic t_throttle();
    mask = 8'hC0; thr_ivl = 3;
    ics_we = 1; ics_data = 8'h80; step(1); ics_we = 0;   // n0+1
    chk("R6 cause set", cause_o, 8'h80);
    chk("R5 irq held", irq_o, 0);
    step(2);
    ics_we = 1; ics_data = 8'h40; step(1); ics_we = 0;   // n0+4
    step(2);
    chk("R5 before window end", irq_o, 0);
    step(1);
    chk("R5 window end no restart", irq_o, 1);
    chk("R6 both bits", cause_o, 8'hC0);
    clear_causes();
    chk("R10 read drops irq", irq_o, 0);
    thr_ivl = 0;
    ics_we = 1; ics_data = 8'h40; step(1); ics_we = 0;
    chk("R5 zero interval immediate", irq_o, 1);
    clear_causes();
  endtask

  // R8: flush on read
  task automatic t_flush();
    mask = 8'h02; thr_ivl = 0;
    rx_dly_rd = 1; step(1); rx_dly_rd = 0;
    chk("R8 read without flag", cause_o, 0);
    chk("R8 no wb without flag", rx_wb_req, 0);
    flush_set = 1; step(1); flush_set = 0;
    chk("R8 flag set", flush_pend, 1);
    rx_dly_rd = 1; step(1); rx_dly_rd = 0;
    chk("R8 flag cleared", flush_pend, 0);
    chk("R8 rx wb", rx_wb_req, 1);
    chk("R8 rx cause", cause_o, 8'h02);
    chk("R8 irq", irq_o, 1);
    clear_causes();
  endtask

  initial begin
    step(3);
    rst_n = 1;
    step(1);
    t_reset();
    t_tx_restart();
    t_tx_abs();
    t_tx_ignored();
    t_rx_timer();
    t_small();
    t_throttle();
    t_flush();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule